// File: doc/BRIEF.md
# Key-locked reset watchdog

This block is a countdown watchdog that sits in a power-management register space of 16-bit registers. It is paced by an enable pulse from a 32.768 kHz time base. Software first writes an unlock key. It then programs a 32-bit timeout as two 16-bit halves and writes the control register to start the count and, optionally, to arm the reset output. If the count runs out while the reset output is armed, the block drives a system reset pulse that lasts a fixed number of ticks.

Two gate bits, one in a module-enable register and one in a clock-enable register, must both be on before the counter moves. A boot-mode status register collects the codes that software records, such as 0x40, 0x20 or 0x80. Only power-on reset clears it, so the code can still be read after the watchdog has reset the system.

Top module: `wdog_keyed_reset`

## Requirements
- R1: After reset the lock register (0xA0) reads 1, the control register (0x88) reads 0, the load halves read 0 and `wdRstOut` is low.
- R2: Writing 0xE551 to the lock register unlocks it, so it reads 0. Writing any other value to it locks it again, so it reads 1.
- R3: While the block is locked, writes to the low load (0x80), high load (0x84) and control (0x88) registers leave them unchanged.
- R4: The two load halves read back what was written. Together they form the 32-bit count {high, low}, so a nonzero high half keeps the counter from expiring within a few ticks.
- R5: When software writes the control register with the run bit (bit 1) set and run was 0, the full count is loaded. Expiry then happens on tick number max(load, 1) after that write.
- R6: The counter moves only while run, module-enable bit 2 (0xC08) and clock-enable bit 2 (0xC18) are all set. Otherwise it holds its value.
- R7: On expiry the run bit clears by itself.
- R8: If the reset-enable bit (bit 3) is set at expiry, `wdRstOut` rises in the cycle after the expiry tick and stays high for exactly 4 ticks. If the bit is clear, `wdRstOut` stays low.
- R9: Each write to the status register (0xEE8) ORs the written data into its value. Bits are never cleared except by `porN`.
- R10: `rstN` low returns every register to its reset value except the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| porN | input | 1 | Power-on reset, active low, clears everything |
| rstN | input | 1 | System reset, active low, spares the status register |
| tick | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 12 | Write offset |
| wrData | input | 16 | Write data |
| rdAddr | input | 12 | Read offset |
| rdData | output | 16 | Read data for `rdAddr`, combinational |
| wdRstOut | output | 1 | System reset request pulse |

## Verification
The assertions assume that a control write never arrives in the same cycle as a counting tick that expires the count. They also assume that `tick` is a single-cycle pulse. The bench drives writes and ticks in separate cycles, and every tick is one cycle high followed by at least one low cycle. The status-register property is disabled only under `porN`, so it still applies across `rstN` pulses.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 12'h084;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h088;
  localparam logic [ADDR_W-1:0] OFS_LOCK    = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFS_MOD_EN  = 12'hC08;
  localparam logic [ADDR_W-1:0] OFS_CLK_EN  = 12'hC18;
  localparam logic [ADDR_W-1:0] OFS_RST_STS = 12'hEE8;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'hE551;
  localparam int RUN_BIT   = 1;
  localparam int RSTEN_BIT = 3;
  localparam int GATE_BIT  = 2;

  typedef struct packed {
    logic wrLoadLo;
    logic wrLoadHi;
    logic wrCtrl;
    logic wrModEn;
    logic wrClkEn;
    logic wrStatus;
    logic loadCnt;
    logic decCnt;
    logic expire;
    logic pulseStart;
    logic pulseDec;
  } strobe_t;

  typedef struct packed {
    logic run;
    logic rstEn;
    logic cntLow;
    logic gateOn;
    logic pulseBusy;
  } dpStat_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              coreRstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  dpStat_t           dpStat,
  output strobe_t           strb,
  output logic              locked
);
  logic cntOn;

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN)                         locked <= 1'b1;
    else if (wrEn && wrAddr == OFS_LOCK)   locked <= (wrData != UNLOCK_KEY);
  end

  always_comb begin
    cntOn           = dpStat.run && dpStat.gateOn;
    strb.wrLoadLo   = wrEn && !locked && wrAddr == OFS_LOAD_LO;
    strb.wrLoadHi   = wrEn && !locked && wrAddr == OFS_LOAD_HI;
    strb.wrCtrl     = wrEn && !locked && wrAddr == OFS_CTRL;
    strb.wrModEn    = wrEn && wrAddr == OFS_MOD_EN;
    strb.wrClkEn    = wrEn && wrAddr == OFS_CLK_EN;
    strb.wrStatus   = wrEn && wrAddr == OFS_RST_STS;
    strb.loadCnt    = strb.wrCtrl && wrData[RUN_BIT] && !dpStat.run;
    strb.expire     = cntOn && tick && dpStat.cntLow;
    strb.decCnt     = cntOn && tick && !dpStat.cntLow;
    strb.pulseStart = strb.expire && dpStat.rstEn;
    strb.pulseDec   = tick && dpStat.pulseBusy && !strb.pulseStart;
  end

  // R2: the correct key always opens the lock on the next cycle
  p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!coreRstN)
    (wrEn && wrAddr == OFS_LOCK && wrData == UNLOCK_KEY) |=> !locked);
  // R2: any other value closes it
  p_bad_key_locks_r2: assert property (@(posedge clk) disable iff (!coreRstN)
    (wrEn && wrAddr == OFS_LOCK && wrData != UNLOCK_KEY) |=> locked);
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int PULSE_TICKS = 4
) (
  input  logic              clk,
  input  logic              coreRstN,
  input  logic              porN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              locked,
  input  strobe_t           strb,
  output dpStat_t           dpStat,
  output logic [DATA_W-1:0] rdData,
  output logic              wdRstOut
);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [DATA_W-1:0] loadLo, loadHi, modEn, clkEn, status;
  logic              run, rstEn;
  logic [CNT_W-1:0]  cnt;
  logic [PW-1:0]     pulseCnt;

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN) begin
      loadLo <= '0; loadHi <= '0; modEn <= '0; clkEn <= '0;
      run <= 1'b0; rstEn <= 1'b0; cnt <= '0; pulseCnt <= '0;
    end else begin
      if (strb.wrLoadLo) loadLo <= wrData;
      if (strb.wrLoadHi) loadHi <= wrData;
      if (strb.wrModEn)  modEn  <= wrData;
      if (strb.wrClkEn)  clkEn  <= wrData;
      if (strb.wrCtrl) begin
        run   <= wrData[RUN_BIT];
        rstEn <= wrData[RSTEN_BIT];
      end
      if (strb.expire) run <= 1'b0;
      if (strb.loadCnt)     cnt <= {loadHi, loadLo};
      else if (strb.decCnt) cnt <= cnt - 1'b1;
      if (strb.pulseStart)    pulseCnt <= PW'(PULSE_TICKS);
      else if (strb.pulseDec) pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              status <= '0;
    else if (strb.wrStatus) status <= status | wrData;
  end

  assign wdRstOut = (pulseCnt != '0);

  always_comb begin
    dpStat.run       = run;
    dpStat.rstEn     = rstEn;
    dpStat.cntLow    = (cnt <= CNT_W'(1));
    dpStat.gateOn    = modEn[GATE_BIT] && clkEn[GATE_BIT];
    dpStat.pulseBusy = wdRstOut;
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      OFS_LOAD_LO: rdData = loadLo;
      OFS_LOAD_HI: rdData = loadHi;
      OFS_CTRL: begin
        rdData[RUN_BIT]   = run;
        rdData[RSTEN_BIT] = rstEn;
      end
      OFS_LOCK:    rdData[0] = locked;
      OFS_MOD_EN:  rdData = modEn;
      OFS_CLK_EN:  rdData = clkEn;
      OFS_RST_STS: rdData = status;
      default:     rdData = '0;
    endcase
  end

  // R3: a locked write leaves the low load half untouched
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!coreRstN)
    (locked && wrEn && wrAddr == OFS_LOAD_LO) |=> $stable(loadLo));
  // R6: without the gate, run and a reload, the count holds
  p_gated_hold_r6: assert property (@(posedge clk) disable iff (!coreRstN)
    (!(run && modEn[GATE_BIT] && clkEn[GATE_BIT]) && !strb.loadCnt) |=> $stable(cnt));
  // R7: expiry drops the run bit
  p_run_drop_r7: assert property (@(posedge clk) disable iff (!coreRstN)
    strb.expire |=> !run);
  // R8: the reset pulse starts only from an armed expiry
  p_pulse_origin_r8: assert property (@(posedge clk) disable iff (!coreRstN)
    $rose(wdRstOut) |-> $past(strb.expire && rstEn));
  // R9: status bits never fall while power-on reset is released
  p_status_keep_r9: assert property (@(posedge clk) disable iff (!porN)
    1'b1 |=> (($past(status) & ~status) == '0));
endmodule

// File: rtl/wdog_keyed_reset.sv
module wdog_keyed_reset
  import wdog_pkg::*;
#(
  parameter int PULSE_TICKS = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              wdRstOut
);
  logic    coreRstN;
  logic    locked;
  strobe_t strb;
  dpStat_t dpStat;

  assign coreRstN = rstN && porN;

  wdog_ctrl i_ctrl (
    .clk(clk), .coreRstN(coreRstN), .tick(tick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .dpStat(dpStat),
    .strb(strb), .locked(locked)
  );

  wdog_datapath #(.PULSE_TICKS(PULSE_TICKS)) i_dp (
    .clk(clk), .coreRstN(coreRstN), .porN(porN), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .locked(locked),
    .strb(strb), .dpStat(dpStat), .rdData(rdData), .wdRstOut(wdRstOut)
  );
endmodule

// File: tb/test_wdog_keyed_reset.sv
`timescale 1ns/1ps
module test_wdog_keyed_reset;
  logic        clk = 1'b0;
  logic        porN = 1'b0, rstN = 1'b0, tick = 1'b0, wrEn = 1'b0;
  logic [11:0] wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        wdRstOut;
  int nChk = 0, nBad = 0;

  localparam logic [11:0] A_LO = 12'h080, A_HI = 12'h084, A_CTL = 12'h088,
                          A_LCK = 12'h0A0, A_MOD = 12'hC08, A_CLK = 12'hC18,
                          A_STS = 12'hEE8;

  typedef struct packed { logic [15:0] lo; logic arm; logic [15:0] ticks; } vec_t;
  localparam vec_t VECS [5] = '{
    '{16'd1, 1'b1, 16'd1}, '{16'd0, 1'b1, 16'd1}, '{16'd5, 1'b1, 16'd5},
    '{16'd3, 1'b0, 16'd3}, '{16'd12, 1'b1, 16'd12}};

  always #2 clk = ~clk;

  wdog_keyed_reset i_wdog_keyed_reset (
    .clk(clk), .porN(porN), .rstN(rstN), .tick(tick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .wdRstOut(wdRstOut));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); rdAddr = a; #1 d = rdData;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    #1;
  endtask

  task automatic ctlWord(input logic run, input logic arm, output logic [15:0] w);
    w = '0; w[1] = run; w[3] = arm;
  endtask

  initial begin
    #800000;
    nBad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [15:0] v, w;
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(A_LCK, v); chk(v == 16'h1, "R1 lock", v, 1);
    rd(A_CTL, v); chk(v == 16'h0, "R1 ctrl", v, 0);
    rd(A_LO, v);  chk(v == 16'h0, "R1 load", v, 0);
    chk(wdRstOut == 1'b0, "R1 rstout", wdRstOut, 0);

    // R3 locked writes ignored
    wr(A_LO, 16'h1234); rd(A_LO, v); chk(v == 16'h0, "R3 lo locked", v, 0);
    wr(A_CTL, 16'h000A); rd(A_CTL, v); chk(v == 16'h0, "R3 ctrl locked", v, 0);

    // R2 unlock, R4 readback, R2 relock, R3 ignored again
    wr(A_LCK, 16'hE551); rd(A_LCK, v); chk(v == 16'h0, "R2 unlock", v, 0);
    wr(A_LO, 16'h1234); rd(A_LO, v); chk(v == 16'h1234, "R4 lo", v, 16'h1234);
    wr(A_LCK, 16'h1111); rd(A_LCK, v); chk(v == 16'h1, "R2 relock", v, 1);
    wr(A_LO, 16'h5555); rd(A_LO, v); chk(v == 16'h1234, "R3 lo relocked", v, 16'h1234);
    wr(A_LCK, 16'hE551);
    wr(A_MOD, 16'h0004); wr(A_CLK, 16'h0004);

    // R5 R7 R8 table walk
    foreach (VECS[i]) begin
      wr(A_LO, VECS[i].lo); wr(A_HI, 16'h0);
      ctlWord(1'b1, VECS[i].arm, w); wr(A_CTL, w);
      for (int k = 1; k < int'(VECS[i].ticks); k++) begin
        tk(); chk(wdRstOut == 1'b0, "R5 early expiry", wdRstOut, 0);
      end
      if (VECS[i].ticks > 1) begin
        rd(A_CTL, v); chk(v[1] == 1'b1, "R5 still running", v[1], 1);
      end
      tk();
      chk(wdRstOut == VECS[i].arm, "R8 pulse start", wdRstOut, VECS[i].arm);
      rd(A_CTL, v); chk(v[1] == 1'b0, "R7 run cleared", v[1], 0);
      if (VECS[i].arm) begin
        for (int p = 1; p <= 4; p++) begin
          tk(); chk(wdRstOut == (p < 4), "R8 pulse width", wdRstOut, (p < 4));
        end
      end else begin
        tk(); chk(wdRstOut == 1'b0, "R8 unarmed no pulse", wdRstOut, 0);
      end
    end

    // R6 gate: module enable off holds the count
    wr(A_MOD, 16'h0000); wr(A_LO, 16'd2);
    ctlWord(1'b1, 1'b1, w); wr(A_CTL, w);
    for (int k = 0; k < 6; k++) tk();
    chk(wdRstOut == 1'b0, "R6 gated hold", wdRstOut, 0);
    rd(A_CTL, v); chk(v[1] == 1'b1, "R6 gated run kept", v[1], 1);
    wr(A_MOD, 16'h0004);
    tk(); chk(wdRstOut == 1'b0, "R6 resume tick1", wdRstOut, 0);
    tk(); chk(wdRstOut == 1'b1, "R6 resume tick2", wdRstOut, 1);
    for (int k = 0; k < 4; k++) tk();
    chk(wdRstOut == 1'b0, "R8 pulse over", wdRstOut, 0);

    // R6 gate: clock enable off
    wr(A_CLK, 16'h0000); wr(A_LO, 16'd1); wr(A_CTL, w);
    for (int k = 0; k < 3; k++) tk();
    chk(wdRstOut == 1'b0, "R6 clk gate", wdRstOut, 0);
    ctlWord(1'b0, 1'b0, w); wr(A_CTL, w); wr(A_CLK, 16'h0004);

    // R4 high half counts
    wr(A_LO, 16'h0); wr(A_HI, 16'h0001);
    rd(A_HI, v); chk(v == 16'h1, "R4 hi readback", v, 1);
    ctlWord(1'b1, 1'b1, w); wr(A_CTL, w);
    for (int k = 0; k < 20; k++) tk();
    chk(wdRstOut == 1'b0, "R4 hi no expiry", wdRstOut, 0);
    rd(A_CTL, v); chk(v[1] == 1'b1, "R4 hi running", v[1], 1);

    // R9 OR accumulate, R10 system reset spares status
    wr(A_STS, 16'h0040); wr(A_STS, 16'h0020);
    rd(A_STS, v); chk(v == 16'h0060, "R9 or accumulate", v, 16'h60);
    @(negedge clk); rstN = 1'b0; @(negedge clk); @(negedge clk); rstN = 1'b1;
    rd(A_STS, v); chk(v == 16'h0060, "R9 survives rstN", v, 16'h60);
    rd(A_LCK, v); chk(v == 16'h1, "R10 lock", v, 1);
    rd(A_CTL, v); chk(v == 16'h0, "R10 ctrl", v, 0);
    rd(A_HI, v);  chk(v == 16'h0, "R10 hi", v, 0);
    rd(A_MOD, v); chk(v == 16'h0, "R10 modEn", v, 0);
    @(negedge clk); porN = 1'b0; @(negedge clk); @(negedge clk); porN = 1'b1;
    rd(A_STS, v); chk(v == 16'h0, "R9 porN clears", v, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule